// File: doc/BRIEF.md
# Indexed Interrupt Routing Table

This block routes a small set of external interrupt lines to processors. Every line has its own routing entry, 64 bits wide, that chooses the vector, the delivery mode, the destination addressing kind and the destination. It also sets the input polarity, chooses edge or level sensing, and holds a mask. When an unmasked line becomes active, the block latches it. It then presents one routing message on a valid/ready output.

Software does not see the registers directly. It sees two 32-bit locations. The first is an index location that selects an internal register. The second is a data window that reads or writes the selected register. Each line's entry is split across two indexed words. The low word holds the control fields and sits at `RT_BASE + 2*pin`. The high word holds the destination and sits at `RT_BASE + 2*pin + 1`. A separate identification register, at its own index, holds a unit number that software can reassign.

Level-sensed lines are handled with an end-of-interrupt input. A delivered level line sets a remote-pending flag. It is not delivered again until an end-of-interrupt arrives with the same vector.

Top module: `irq_redir_unit`

## Requirements
- R1: After reset, the index register reads 0 and every entry's low word reads 0x0001_0000 (masked, all other fields 0). Every high word reads 0, the identification register reads 0 and `msg_valid` is 0.
- R2: A write with `cpu_sel`=0 loads the index, and a read with `cpu_sel`=0 returns it. A write or read with `cpu_sel`=1 goes to the register the index selects. Read data appears on `cpu_rdata` one clock after `cpu_rd_en`.
- R3: The low word of pin p is at index RT_BASE+2p and the high word is at RT_BASE+2p+1. The low word fields are: [7:0] vector, [10:8] delivery mode, [11] logical destination, [12] delivery status (read-only), [13] active-low polarity, [14] remote pending (read-only), [15] level sensing and [16] mask. In the high word, bits [31:24] hold the destination. Unlisted bits and unmapped indexes read 0.
- R4: The delivery mode is passed to `msg_mode` unchanged. The codes are: 0 fixed, 1 lowest priority, 2 system management, 3 reserved, 4 non-maskable, 5 init, 6 startup, 7 external controller.
- R5: A transition that arrives while a pin is masked is discarded and produces no message. A masked pin reads delivery status 0.
- R6: An edge-sensed pin latches one request per activating transition. That transition is a rise for active-high and a fall for active-low. Holding the input active does not repeat the request.
- R7: A delivered level-sensed pin sets remote pending (bit 14). No further message comes from that pin until an end-of-interrupt carries its vector. An end-of-interrupt with another vector has no effect. If the line is still active after the matching end-of-interrupt, it is delivered again.
- R8: Delivery status (bit 12) reads 1 from the cycle the pin is latched until its message is accepted with `msg_valid` and `msg_ready` both high.
- R9: When several pins are pending, the lowest-numbered unmasked pin is sent first, with one message per accepted handshake. A message that is not yet accepted holds its fields stable.
- R10: The identification register at index ID_IDX keeps bits [27:24] as a writable number. Its other bits read 0.
- R11: A message carries the entry's vector, delivery mode, logical-destination bit, destination byte and level-sensing bit, as they were when the message was loaded.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cpu_wr_en | input | 1 | Register write strobe |
| cpu_rd_en | input | 1 | Register read strobe |
| cpu_sel | input | 1 | 0 selects the index location, 1 selects the data window |
| cpu_wdata | input | 32 | Write data |
| cpu_rdata | output | 32 | Registered read data |
| irq_in | input | NPINS | External interrupt lines |
| eoi_valid | input | 1 | End-of-interrupt strobe |
| eoi_vector | input | 8 | Vector of the finished interrupt |
| msg_valid | output | 1 | Routing message present |
| msg_ready | input | 1 | Routing message accepted |
| msg_vector | output | 8 | Message vector |
| msg_mode | output | 3 | Message delivery mode |
| msg_logical | output | 1 | 1 for logical destination addressing |
| msg_dest | output | 8 | Message destination |
| msg_level | output | 1 | 1 when the source pin is level-sensed |

## Verification
Random rounds program every entry with random vectors, modes, addressing bits and destinations. Each round then fires a random group of pins at once while the output is stalled. The order of the drained messages shows whether the priority is lowest-pin-first, and the fields show whether each message took its own pin's entry. Directed cases cover the remaining behaviour:
- A held line and a re-toggled line tell one latch per transition apart from one latch per level.
- A low-polarity line fired by a fall checks the polarity setting.
- A pulse while masked, followed by an unmask, checks that masked transitions are discarded.
- A level line sent end-of-interrupts with a wrong vector and then the right vector separates the remote-pending hold from its release.
- A sweep of all eight mode codes checks the delivery mode field.

// File: rtl/irq_redir_pkg.sv
package irq_redir_pkg;

  // low-word field positions
  localparam int F_VEC_LSB  = 0;
  localparam int F_MODE_LSB = 8;
  localparam int F_LOGICAL  = 11;
  localparam int F_STATUS   = 12;
  localparam int F_POL_LOW  = 13;
  localparam int F_RPEND    = 14;
  localparam int F_LEVEL    = 15;
  localparam int F_MASK     = 16;
  localparam int F_DEST_LSB = 24;

  typedef struct packed {
    logic [7:0] dest;
    logic       mask;
    logic       level;
    logic       pol_low;
    logic       logical;
    logic [2:0] mode;
    logic [7:0] vector;
  } route_entry_t;

  localparam route_entry_t ENTRY_RESET = '{mask: 1'b1, default: '0};

endpackage

// File: rtl/irq_pin_ctrl.sv
module irq_pin_ctrl (
  input  logic       clk,
  input  logic       rst,
  input  logic       irq_i,
  input  logic       pol_low_i,
  input  logic       level_i,
  input  logic       mask_i,
  input  logic [7:0] vector_i,
  input  logic       eoi_valid_i,
  input  logic [7:0] eoi_vector_i,
  input  logic       accept_i,
  output logic       pend_o,
  output logic       rpend_o
);

  logic irq_q, act_prev, pend_q, rpend_q;
  logic act_now, set_edge, set_level, eoi_hit;

  assign act_now   = irq_q ^ pol_low_i;
  assign set_edge  = !level_i && act_now && !act_prev && !mask_i;
  assign set_level = level_i && act_now && !rpend_q && !mask_i && !accept_i;
  assign eoi_hit   = eoi_valid_i && (eoi_vector_i == vector_i);

  always_ff @(posedge clk) begin
    if (rst) begin
      irq_q    <= 1'b0;
      act_prev <= 1'b0;
      pend_q   <= 1'b0;
      rpend_q  <= 1'b0;
    end else begin
      irq_q    <= irq_i;
      act_prev <= act_now;
      if (set_edge || set_level) pend_q <= 1'b1;
      else if (accept_i)         pend_q <= 1'b0;
      if (accept_i && level_i)   rpend_q <= 1'b1;
      else if (eoi_hit)          rpend_q <= 1'b0;
    end
  end

  assign pend_o  = pend_q;
  assign rpend_o = rpend_q;

  // R5: a request is only latched while the pin is unmasked
  p_latch_unmasked_r5: assert property (@(posedge clk) disable iff (rst)
    $rose(pend_q) |-> !$past(mask_i));

  // R7: remote pending rises only on acceptance of a level-sensed pin
  p_rpend_on_accept_r7: assert property (@(posedge clk) disable iff (rst)
    $rose(rpend_q) |-> $past(accept_i && level_i));

  // R8: acceptance only happens for a latched request
  p_accept_pending_r8: assert property (@(posedge clk) disable iff (rst)
    accept_i |-> pend_q);

endmodule

// File: rtl/irq_prio_pick.sv
module irq_prio_pick #(
  parameter int N = 4,
  parameter int W = 2
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [N-1:0] req,
  output logic         grant_any,
  output logic [W-1:0] grant_idx
);

  always_comb begin
    grant_any = 1'b0;
    grant_idx = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (req[i]) begin
        grant_any = 1'b1;
        grant_idx = W'(i);
      end
    end
  end

  // R9: the pick is a requester and no lower-numbered pin is requesting
  p_pick_lowest_r9: assert property (@(posedge clk) disable iff (rst)
    grant_any |-> (req[grant_idx] && ((req & ~({N{1'b1}} << grant_idx)) == '0)));

  p_pick_any_r9: assert property (@(posedge clk) disable iff (rst)
    (req != '0) |-> grant_any);

endmodule

// File: rtl/irq_redir_unit.sv
module irq_redir_unit
  import irq_redir_pkg::*;
#(
  parameter int NPINS   = 4,
  parameter int IDX_W   = 8,
  parameter int RT_BASE = 16,
  parameter int ID_IDX  = 0,
  parameter int ID_W    = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             cpu_wr_en,
  input  logic             cpu_rd_en,
  input  logic             cpu_sel,
  input  logic [31:0]      cpu_wdata,
  output logic [31:0]      cpu_rdata,
  input  logic [NPINS-1:0] irq_in,
  input  logic             eoi_valid,
  input  logic [7:0]       eoi_vector,
  output logic             msg_valid,
  input  logic             msg_ready,
  output logic [7:0]       msg_vector,
  output logic [2:0]       msg_mode,
  output logic             msg_logical,
  output logic [7:0]       msg_dest,
  output logic             msg_level
);

  localparam int PIN_W   = (NPINS > 1) ? $clog2(NPINS) : 1;
  localparam int RT_LAST = RT_BASE + 2 * NPINS - 1;

  route_entry_t     cfg [NPINS];
  logic [IDX_W-1:0] idx_q;
  logic [ID_W-1:0]  id_q;
  logic [NPINS-1:0] pend, rpend, accept_vec, req;
  logic [PIN_W-1:0] msg_pin, grant_idx, sel_pin;
  logic [IDX_W-1:0] off;
  logic             in_table, sel_hi, grant_any, accept;

  assign off      = idx_q - IDX_W'(RT_BASE);
  assign in_table = (idx_q >= IDX_W'(RT_BASE)) && (idx_q <= IDX_W'(RT_LAST));
  assign sel_pin  = off[PIN_W:1];
  assign sel_hi   = off[0];

  logic unused_bits;
  assign unused_bits = ^{cpu_wdata[23:17], cpu_wdata[14], cpu_wdata[12],
                         off[IDX_W-1:PIN_W+1]};

  // register writes through the index / window pair
  always_ff @(posedge clk) begin
    if (rst) begin
      idx_q <= '0;
      id_q  <= '0;
      for (int i = 0; i < NPINS; i++) cfg[i] <= ENTRY_RESET;
    end else if (cpu_wr_en) begin
      if (!cpu_sel) begin
        idx_q <= cpu_wdata[IDX_W-1:0];
      end else if (idx_q == IDX_W'(ID_IDX)) begin
        id_q <= cpu_wdata[F_DEST_LSB +: ID_W];
      end else if (in_table) begin
        if (sel_hi) begin
          cfg[sel_pin].dest <= cpu_wdata[F_DEST_LSB +: 8];
        end else begin
          cfg[sel_pin].vector  <= cpu_wdata[F_VEC_LSB +: 8];
          cfg[sel_pin].mode    <= cpu_wdata[F_MODE_LSB +: 3];
          cfg[sel_pin].logical <= cpu_wdata[F_LOGICAL];
          cfg[sel_pin].pol_low <= cpu_wdata[F_POL_LOW];
          cfg[sel_pin].level   <= cpu_wdata[F_LEVEL];
          cfg[sel_pin].mask    <= cpu_wdata[F_MASK];
        end
      end
    end
  end

  // registered read port
  always_ff @(posedge clk) begin
    if (rst) begin
      cpu_rdata <= '0;
    end else if (cpu_rd_en) begin
      if (!cpu_sel)
        cpu_rdata <= 32'(idx_q);
      else if (idx_q == IDX_W'(ID_IDX))
        cpu_rdata <= 32'(id_q) << F_DEST_LSB;
      else if (in_table && sel_hi)
        cpu_rdata <= {cfg[sel_pin].dest, 24'h0};
      else if (in_table)
        cpu_rdata <= {15'h0, cfg[sel_pin].mask, cfg[sel_pin].level,
                      rpend[sel_pin], cfg[sel_pin].pol_low, pend[sel_pin],
                      cfg[sel_pin].logical, cfg[sel_pin].mode,
                      cfg[sel_pin].vector};
      else
        cpu_rdata <= '0;
    end
  end

  // per-pin sensing
  assign accept     = msg_valid && msg_ready;
  assign accept_vec = accept ? (NPINS'(1) << msg_pin) : '0;

  for (genvar p = 0; p < NPINS; p++) begin : gen_pin
    irq_pin_ctrl u_pin (
      .clk          (clk),
      .rst          (rst),
      .irq_i        (irq_in[p]),
      .pol_low_i    (cfg[p].pol_low),
      .level_i      (cfg[p].level),
      .mask_i       (cfg[p].mask),
      .vector_i     (cfg[p].vector),
      .eoi_valid_i  (eoi_valid),
      .eoi_vector_i (eoi_vector),
      .accept_i     (accept_vec[p]),
      .pend_o       (pend[p]),
      .rpend_o      (rpend[p])
    );
    assign req[p] = pend[p] && !cfg[p].mask;
  end

  irq_prio_pick #(.N(NPINS), .W(PIN_W)) u_pick (
    .clk       (clk),
    .rst       (rst),
    .req       (req),
    .grant_any (grant_any),
    .grant_idx (grant_idx)
  );

  // registered message slot
  always_ff @(posedge clk) begin
    if (rst) begin
      msg_valid   <= 1'b0;
      msg_pin     <= '0;
      msg_vector  <= '0;
      msg_mode    <= '0;
      msg_logical <= 1'b0;
      msg_dest    <= '0;
      msg_level   <= 1'b0;
    end else if (!msg_valid && grant_any) begin
      msg_valid   <= 1'b1;
      msg_pin     <= grant_idx;
      msg_vector  <= cfg[grant_idx].vector;
      msg_mode    <= cfg[grant_idx].mode;
      msg_logical <= cfg[grant_idx].logical;
      msg_dest    <= cfg[grant_idx].dest;
      msg_level   <= cfg[grant_idx].level;
    end else if (accept) begin
      msg_valid <= 1'b0;
    end
  end

  // R9: a stalled message keeps its contents
  p_msg_hold_r9: assert property (@(posedge clk) disable iff (rst)
    (msg_valid && !msg_ready) |=> (msg_valid && $stable(msg_vector) &&
                                   $stable(msg_dest) && $stable(msg_mode)));

  // R8: the pin behind an outstanding message still shows delivery status
  p_inflight_pending_r8: assert property (@(posedge clk) disable iff (rst)
    msg_valid |-> pend[msg_pin]);

endmodule

// File: tb/irq_redir_unit_bench.sv
module irq_redir_unit_bench;
  localparam int CLK_PERIOD = 10;
  localparam int NP   = 4;
  localparam int BASE = 16;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic cpu_wr_en = 0, cpu_rd_en = 0, cpu_sel = 0;
  logic [31:0] cpu_wdata = '0, cpu_rdata;
  logic [NP-1:0] irq_in = '0;
  logic eoi_valid = 0;
  logic [7:0] eoi_vector = '0;
  logic msg_valid, msg_ready = 0, msg_logical, msg_level;
  logic [7:0] msg_vector, msg_dest;
  logic [2:0] msg_mode;

  int n_checks = 0, n_fail = 0;
  bit finished = 0;

  logic [7:0] bvec [NP];
  logic [2:0] bmode [NP];
  logic       blog [NP];
  logic [7:0] bdest [NP];

  always #(CLK_PERIOD/2) clk = ~clk;

  irq_redir_unit u_irq_redir_unit (
    .clk(clk), .rst(rst), .cpu_wr_en(cpu_wr_en), .cpu_rd_en(cpu_rd_en),
    .cpu_sel(cpu_sel), .cpu_wdata(cpu_wdata), .cpu_rdata(cpu_rdata),
    .irq_in(irq_in), .eoi_valid(eoi_valid), .eoi_vector(eoi_vector),
    .msg_valid(msg_valid), .msg_ready(msg_ready), .msg_vector(msg_vector),
    .msg_mode(msg_mode), .msg_logical(msg_logical), .msg_dest(msg_dest),
    .msg_level(msg_level));

  function automatic logic [31:0] low_word(logic [7:0] v, logic [2:0] m,
      logic lg, logic pol, logic lvl, logic msk, logic st, logic rp);
    return {15'h0, msk, lvl, rp, pol, st, lg, m, v};
  endfunction

  task automatic check(string tag, logic [63:0] got, logic [63:0] exp);
    n_checks++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s: got %h expected %h", tag, got, exp);
    end
  endtask

  task automatic reg_wr(logic sel, logic [31:0] d);
    @(negedge clk); cpu_wr_en = 1; cpu_sel = sel; cpu_wdata = d;
    @(negedge clk); cpu_wr_en = 0;
  endtask

  task automatic reg_rd(logic sel, output logic [31:0] d);
    @(negedge clk); cpu_rd_en = 1; cpu_sel = sel;
    @(negedge clk); cpu_rd_en = 0; d = cpu_rdata;
  endtask

  task automatic win_wr(int idx, logic [31:0] d);
    reg_wr(0, 32'(idx)); reg_wr(1, d);
  endtask

  task automatic win_rd(int idx, output logic [31:0] d);
    reg_wr(0, 32'(idx)); reg_rd(1, d);
  endtask

  task automatic cfg_pin(int p, logic [7:0] v, logic [2:0] m, logic lg,
      logic pol, logic lvl, logic msk, logic [7:0] dst);
    win_wr(BASE + 2*p, low_word(v, m, lg, pol, lvl, msk, 1'b0, 1'b0));
    win_wr(BASE + 2*p + 1, {dst, 24'h0});
    bvec[p] = v; bmode[p] = m; blog[p] = lg; bdest[p] = dst;
  endtask

  task automatic idle(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic expect_msg(string tag, int p, logic lvl);
    int waited = 0;
    while (!msg_valid && waited < 20) begin @(negedge clk); waited++; end
    check({tag, " valid"}, 64'(msg_valid), 64'd1);
    check({tag, " fields"}, {29'h0, msg_vector, msg_mode, msg_logical, msg_dest, msg_level},
          {29'h0, bvec[p], bmode[p], blog[p], bdest[p], lvl});
    msg_ready = 1; @(negedge clk); msg_ready = 0;
  endtask

  task automatic expect_none(string tag);
    idle(8);
    check(tag, 64'(msg_valid), 64'd0);
  endtask

  task automatic pulse(int p);
    @(negedge clk); irq_in[p] = 1; idle(3); irq_in[p] = 0; idle(3);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      n_checks++; n_fail++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
      $finish;
    end
  end

  initial begin
    logic [31:0] d;
    logic [31:0] seed;
    logic [NP-1:0] fire;
    logic [7:0] hv, hd;
    seed = $urandom(32'd1234);
    idle(3); rst = 0; idle(1);

    // R1 reset state
    check("R1 msg_valid", 64'(msg_valid), 0);
    reg_rd(0, d); check("R1 index", 64'(d), 0);
    for (int p = 0; p < NP; p++) begin
      reg_wr(0, 32'(BASE + 2*p)); reg_rd(1, d); check("R1 low word", 64'(d), 64'h0001_0000);
      reg_wr(0, 32'(BASE + 2*p + 1)); reg_rd(1, d); check("R1 high word", 64'(d), 0);
    end
    reg_wr(0, 0); reg_rd(1, d); check("R1 id", 64'(d), 0);

    // R2 index readback
    reg_wr(0, 32'h15); reg_rd(0, d); check("R2 index readback", 64'(d), 64'h15);
    win_rd(200, d); check("R3 unmapped index", 64'(d), 0);

    // R3 layout, read-only and reserved bits
    win_wr(BASE + 4, 32'hFFFF_FFFF); win_rd(BASE + 4, d);
    check("R3 low all-ones", 64'(d), 64'h0001_AFFF);
    win_wr(BASE + 5, 32'hFFFF_FFFF); win_rd(BASE + 5, d);
    check("R3 high all-ones", 64'(d), 64'hFF00_0000);
    win_rd(BASE + 6, d); check("R3 neighbour untouched", 64'(d), 64'h0001_0000);
    cfg_pin(2, 8'h00, 3'd0, 0, 0, 0, 1, 8'h00);

    // R10 identification register
    win_wr(0, 32'hFFFF_FFFF); win_rd(0, d); check("R10 id write", 64'(d), 64'h0F00_0000);
    win_wr(0, 32'h0500_0000); win_rd(0, d); check("R10 id reassign", 64'(d), 64'h0500_0000);

    // R6 edge, active-high, R11 fields
    cfg_pin(1, 8'h41, 3'd0, 1, 0, 0, 0, 8'h22);
    @(negedge clk); irq_in[1] = 1;
    expect_msg("R6 R11 first edge", 1, 0);
    expect_none("R6 held level no repeat");
    irq_in[1] = 0; idle(3); irq_in[1] = 1;
    expect_msg("R6 second edge", 1, 0);
    irq_in[1] = 0; idle(3);

    // R6 active-low polarity
    cfg_pin(3, 8'h77, 3'd4, 0, 1, 0, 1, 8'h09);
    idle(3);
    cfg_pin(3, 8'h77, 3'd4, 0, 1, 0, 0, 8'h09);
    expect_none("R6 low polarity idle");
    irq_in[3] = 1;
    expect_none("R6 low polarity rise ignored");
    irq_in[3] = 0;
    expect_msg("R6 low polarity fall", 3, 0);

    // R5 mask
    cfg_pin(0, 8'h30, 3'd0, 0, 0, 0, 1, 8'h01);
    pulse(0);
    expect_none("R5 masked pulse");
    win_rd(BASE, d); check("R5 masked status", 64'(d[12]), 0);
    cfg_pin(0, 8'h30, 3'd0, 0, 0, 0, 0, 8'h01);
    expect_none("R5 discarded after unmask");

    // R8 delivery status
    pulse(0);
    win_rd(BASE, d); check("R8 status while stalled", 64'(d[12]), 1);
    expect_msg("R8 delivery", 0, 0);
    win_rd(BASE, d); check("R8 status after accept", 64'(d[12]), 0);

    // R7 level sensing with end-of-interrupt
    cfg_pin(2, 8'h55, 3'd1, 1, 0, 1, 0, 8'h0C);
    @(negedge clk); irq_in[2] = 1;
    expect_msg("R7 level first", 2, 1);
    win_rd(BASE + 4, d); check("R7 remote pending set", 64'(d[14]), 1);
    expect_none("R7 held off");
    @(negedge clk); eoi_vector = 8'h56; eoi_valid = 1; @(negedge clk); eoi_valid = 0;
    expect_none("R7 wrong vector eoi");
    @(negedge clk); eoi_vector = 8'h55; eoi_valid = 1; @(negedge clk); eoi_valid = 0;
    expect_msg("R7 redelivery after eoi", 2, 1);
    irq_in[2] = 0;
    @(negedge clk); eoi_vector = 8'h55; eoi_valid = 1; @(negedge clk); eoi_valid = 0;
    expect_none("R7 inactive after eoi");
    win_rd(BASE + 4, d); check("R7 remote pending cleared", 64'(d[14]), 0);

    // R4 delivery mode sweep
    for (int m = 0; m < 8; m++) begin
      cfg_pin(1, 8'h60 + 8'(m), 3'(m), 0, 0, 0, 0, 8'h33);
      pulse(1);
      expect_msg("R4 mode passthrough", 1, 0);
    end

    // R9 random groups, lowest pin first, stalled message stable
    for (int r = 0; r < 20; r++) begin
      for (int p = 0; p < NP; p++)
        cfg_pin(p, 8'($urandom), 3'($urandom), 1'($urandom), 0, 0, 0, 8'($urandom));
      fire = NP'($urandom);
      if (fire == '0) fire = NP'(1) << ($urandom % NP);
      @(negedge clk); irq_in = fire;
      idle(6);
      hv = msg_vector; hd = msg_dest; idle(3);
      check("R9 stalled message stable", {hv, hd}, {msg_vector, msg_dest});
      for (int p = 0; p < NP; p++)
        if (fire[p]) expect_msg("R9 lowest first", p, 0);
      expect_none("R9 drained");
      irq_in = '0; idle(3);
    end

    finished = 1;
    $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
    $finish;
  end
endmodule